// File: doc/BRIEF.md
# Generator-Address Marshal Buffer

This block sits beside one core and keeps a short list of cache-block addresses. Stores that carry the generator tag put the address of the block they write into this list. When a marshal command arrives, the block sends every address in the list, in the order it was recorded, to one destination core. It sends them as a stream of push requests on a valid/ready channel toward the interconnect, and then the list is empty again.

The marshal command names its target in one of two ways. It can give a physical core number directly, or it can give a segment number that a small binding table turns into a core number. The binding table can be rewritten at any time. The core number is fixed when the command is accepted and stays fixed for the whole drain. Pushes are only a hint to the remote cache, so an address that is dropped or sent to no purpose costs bandwidth and is not an error.

An address already in the list is not entered a second time. When the list is full, further new addresses are discarded. A tagged store that arrives while a drain is running is held in a single spare slot and becomes the first entry of the next list.

Top module: `gen_marshal_buf`

## Requirements
- R1: After reset the list is empty, `push_valid` is low, and the binding table maps every segment s to core s. A marshal command given right after reset therefore produces no push.
- R2: When `gen_valid` is high at a clock edge while no drain is running, `gen_addr` is appended to the list. A later marshal pushes the entries in the order they were appended, one entry for each edge at which `push_valid` and `push_ready` are both high.
- R3: A tagged address that matches an entry already in the list leaves the list unchanged.
- R4: The list holds at most ENTRIES addresses. A new address offered while the list is full is discarded.
- R5: While `push_valid` is high and `push_ready` is low, `push_valid` stays high and `push_addr` and `push_core` do not change.
- R6: With `mar_is_seg` = 1, the destination is the binding-table entry indexed by the low SEG_W bits of `mar_arg`. With `mar_is_seg` = 0, the destination is `mar_arg` itself.
- R7: A binding write (`bind_we`) sets the entry for `bind_seg` to `bind_core` at that edge. A drain that is already running keeps the core it captured when its marshal command was accepted.
- R8: The edge that accepts the last push of a drain empties the list, so a following marshal with no new tagged stores produces no push.
- R9: The first tagged address that arrives during a drain is held and becomes entry 0 of the list at the edge that ends the drain. Further tagged addresses during the same drain are discarded.
- R10: A marshal command is ignored while a drain is running. A marshal command given with an empty list, and with no tagged store in the same cycle, produces no push.
- R11: `push_valid` goes high in the cycle right after the edge that accepts a marshal command for a non-empty list.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gen_valid | input | 1 | A generator-tagged store writes `gen_addr` this cycle |
| gen_addr | input | ADDR_W | Cache-block address written by the tagged store |
| bind_we | input | 1 | Write the binding table this cycle |
| bind_seg | input | SEG_W | Segment entry to rewrite |
| bind_core | input | CORE_W | Physical core to store for that segment |
| mar_valid | input | 1 | Marshal command this cycle |
| mar_is_seg | input | 1 | 1: `mar_arg` is a segment number; 0: it is a core number |
| mar_arg | input | CORE_W | Marshal target argument |
| push_valid | output | 1 | A push request is offered |
| push_ready | input | 1 | Interconnect takes the offered push |
| push_addr | output | ADDR_W | Block address to push |
| push_core | output | CORE_W | Destination core of the push |

## Verification
A tagged store or a binding write takes effect at the edge where it is sampled. The first push is offered one cycle after the edge that accepts the marshal, and the next entry shows up one cycle after each accepting edge. The bench drives every input and reads every output at the falling edge. It records a push only at the falling edge where it raises `push_ready` while `push_valid` is high, because that push completes at the next rising edge. The bench compares the recorded address and core stream, in order, against a list it builds from the addresses it offered, the dedup and capacity rules, and its own copy of the bindings. While it holds `push_ready` low, it checks in every cycle that the offered push does not change.

// File: rtl/gen_marshal_buf.sv
module gen_marshal_buf #(
  parameter int ENTRIES = 16,
  parameter int ADDR_W  = 48,
  parameter int SEG_W   = 4,
  parameter int CORE_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gen_valid,
  input  logic [ADDR_W-1:0] gen_addr,
  input  logic              bind_we,
  input  logic [SEG_W-1:0]  bind_seg,
  input  logic [CORE_W-1:0] bind_core,
  input  logic              mar_valid,
  input  logic              mar_is_seg,
  input  logic [CORE_W-1:0] mar_arg,
  output logic              push_valid,
  input  logic              push_ready,
  output logic [ADDR_W-1:0] push_addr,
  output logic [CORE_W-1:0] push_core
);
  localparam int CNT_W = $clog2(ENTRIES + 1);
  localparam int PTR_W = $clog2(ENTRIES);
  localparam int SEGS  = 1 << SEG_W;

  logic [ADDR_W-1:0] mem      [ENTRIES];
  logic [CORE_W-1:0] bind_tbl [SEGS];
  logic [CNT_W-1:0]  count;
  logic [PTR_W-1:0]  rd_ptr;
  logic [CORE_W-1:0] dest;
  logic              draining;
  logic              hold_v;
  logic [ADDR_W-1:0] hold_addr;
  logic [ENTRIES-1:0] hit;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign hit[i] = (CNT_W'(i) < count) && (mem[i] == gen_addr);
  end

  wire              full       = (count == CNT_W'(ENTRIES));
  wire              accept_gen = gen_valid && !draining && !(|hit) && !full;
  wire [CORE_W-1:0] mar_core   = mar_is_seg ? bind_tbl[mar_arg[SEG_W-1:0]] : mar_arg;
  wire              start      = mar_valid && !draining && (count != '0 || accept_gen);
  wire              push_fire  = push_valid && push_ready;
  wire              last       = (CNT_W'(rd_ptr) == count - CNT_W'(1));

  assign push_valid = draining;
  assign push_addr  = mem[rd_ptr];
  assign push_core  = dest;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SEGS; s++) bind_tbl[s] <= CORE_W'(s);
    end else if (bind_we) begin
      bind_tbl[bind_seg] <= bind_core;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count     <= '0;
      rd_ptr    <= '0;
      dest      <= '0;
      draining  <= 1'b0;
      hold_v    <= 1'b0;
      hold_addr <= '0;
    end else begin
      if (accept_gen) begin
        mem[PTR_W'(count)] <= gen_addr;
        count              <= count + CNT_W'(1);
      end
      if (start) begin
        draining <= 1'b1;
        rd_ptr   <= '0;
        dest     <= mar_core;
      end
      if (draining && gen_valid && !hold_v) begin
        hold_v    <= 1'b1;
        hold_addr <= gen_addr;
      end
      if (push_fire) begin
        rd_ptr <= rd_ptr + PTR_W'(1);
        if (last) begin
          draining <= 1'b0;
          rd_ptr   <= '0;
          hold_v   <= 1'b0;
          if (hold_v) begin
            mem[0] <= hold_addr;
            count  <= CNT_W'(1);
          end else if (gen_valid) begin
            mem[0] <= gen_addr;
            count  <= CNT_W'(1);
          end else begin
            count  <= '0;
          end
        end
      end
    end
  end

  p_count_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(ENTRIES));

  p_push_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid && !push_ready |=> push_valid && $stable(push_addr) && $stable(push_core));

  p_dest_steady_r7: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid && $past(push_valid) |-> $stable(push_core));

  p_empty_after_r8: assert property (@(posedge clk) disable iff (!rst_n)
    push_fire && last |=> !push_valid && count <= CNT_W'(1));

  p_list_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    draining && !(push_fire && last) |=> $stable(count));

  p_start_offer_r11: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> push_valid);
endmodule

// File: tb/gen_marshal_buf_tb_top.sv
`timescale 1ns/1ps
module gen_marshal_buf_tb_top;
  localparam int ENT = 4, AW = 12, SW = 2, CW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic gen_valid = 1'b0, bind_we = 1'b0, mar_valid = 1'b0, mar_is_seg = 1'b0, push_ready = 1'b0;
  logic [AW-1:0] gen_addr = '0;
  logic [SW-1:0] bind_seg = '0;
  logic [CW-1:0] bind_core = '0, mar_arg = '0;
  logic push_valid;
  logic [AW-1:0] push_addr;
  logic [CW-1:0] push_core;

  int errors = 0, checks = 0;
  int n_got = 0, n_exp = 0;
  logic [AW-1:0] got_a [32];
  logic [CW-1:0] got_c [32];
  logic [AW-1:0] exp_a [32];
  logic [CW-1:0] exp_c [32];
  bit stalled = 0;
  logic [AW-1:0] st_a;
  logic [CW-1:0] st_c;
  bit finished = 0;

  always #2.5 clk = ~clk;

  gen_marshal_buf #(.ENTRIES(ENT), .ADDR_W(AW), .SEG_W(SW), .CORE_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .gen_valid(gen_valid), .gen_addr(gen_addr),
    .bind_we(bind_we), .bind_seg(bind_seg), .bind_core(bind_core),
    .mar_valid(mar_valid), .mar_is_seg(mar_is_seg), .mar_arg(mar_arg),
    .push_valid(push_valid), .push_ready(push_ready),
    .push_addr(push_addr), .push_core(push_core));

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cycle(input logic rdy);
    push_ready = rdy;
    if (push_valid) begin
      if (stalled)
        chk(push_addr == st_a && push_core == st_c, "R5", "stalled push changed",
            {push_core, push_addr}, {st_c, st_a});
      if (rdy && n_got < 32) begin
        got_a[n_got] = push_addr;
        got_c[n_got] = push_core;
        n_got++;
      end
    end
    stalled = push_valid && !rdy;
    st_a = push_addr;
    st_c = push_core;
    @(negedge clk);
    gen_valid = 1'b0; mar_valid = 1'b0; bind_we = 1'b0;
  endtask

  task automatic rec(input logic [AW-1:0] a);
    gen_valid = 1'b1; gen_addr = a;
    cycle(1'b1);
  endtask

  task automatic marshal(input logic seg, input logic [CW-1:0] arg);
    mar_valid = 1'b1; mar_is_seg = seg; mar_arg = arg;
    cycle(1'b1);
  endtask

  task automatic bind_set(input logic [SW-1:0] s, input logic [CW-1:0] c);
    bind_we = 1'b1; bind_seg = s; bind_core = c;
    cycle(1'b1);
  endtask

  task automatic drain_all();
    repeat (3 * ENT + 4) cycle(1'b1);
  endtask

  task automatic add_exp(input logic [AW-1:0] a, input logic [CW-1:0] c);
    exp_a[n_exp] = a; exp_c[n_exp] = c; n_exp++;
  endtask

  task automatic expect_log(input string req);
    chk(n_got == n_exp, req, "push count", n_got, n_exp);
    for (int i = 0; i < n_exp && i < n_got; i++)
      chk(got_a[i] == exp_a[i] && got_c[i] == exp_c[i], req, "push core/addr",
          {got_c[i], got_a[i]}, {exp_c[i], exp_a[i]});
    n_got = 0; n_exp = 0;
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 / R10: empty after reset
    chk(push_valid == 1'b0, "R1", "push_valid after reset", push_valid, 0);
    marshal(1'b0, 3'd5);
    chk(push_valid == 1'b0, "R10", "push on empty marshal", push_valid, 0);
    drain_all();
    expect_log("R1");

    // R1 / R6 / R11: identity bindings for every segment
    for (int s = 0; s < (1 << SW); s++) begin
      rec(AW'(12'h100 + s));
      marshal(1'b1, CW'(s));
      chk(push_valid == 1'b1, "R11", "push_valid after marshal", push_valid, 1);
      drain_all();
      add_exp(AW'(12'h100 + s), CW'(s));
      expect_log("R1");
    end

    // R6: direct core argument for every core
    for (int c = 0; c < (1 << CW); c++) begin
      rec(AW'(12'h300 + c));
      marshal(1'b0, CW'(c));
      drain_all();
      add_exp(AW'(12'h300 + c), CW'(c));
      expect_log("R6");
    end

    // R2 / R6 / R7: rebound segments, every fill level
    for (int s = 0; s < (1 << SW); s++) bind_set(SW'(s), CW'(7 - s));
    for (int s = 0; s < (1 << SW); s++) begin
      for (int k = 0; k <= s; k++) begin
        rec(AW'(12'h200 + 16 * s + k));
        add_exp(AW'(12'h200 + 16 * s + k), CW'(7 - s));
      end
      marshal(1'b1, CW'(s));
      drain_all();
      expect_log("R2");
    end

    // R3: duplicates not recorded
    rec(12'h0A1); rec(12'h0B2); rec(12'h0A1); rec(12'h0C3); rec(12'h0B2);
    marshal(1'b0, 3'd0);
    drain_all();
    add_exp(12'h0A1, 0); add_exp(12'h0B2, 0); add_exp(12'h0C3, 0);
    expect_log("R3");

    // R4: overflow discarded
    for (int k = 0; k < ENT + 2; k++) rec(AW'(12'h400 + k));
    marshal(1'b0, 3'd7);
    drain_all();
    for (int k = 0; k < ENT; k++) add_exp(AW'(12'h400 + k), 3'd7);
    expect_log("R4");

    // R5: back-pressure pattern
    rec(12'h811); rec(12'h822); rec(12'h833);
    marshal(1'b0, 3'd6);
    for (int i = 0; i < 14; i++) cycle(logic'(i % 2));
    add_exp(12'h811, 6); add_exp(12'h822, 6); add_exp(12'h833, 6);
    expect_log("R5");

    // R8: list empty after drain
    marshal(1'b0, 3'd6);
    drain_all();
    expect_log("R8");

    // R7: rebinding during a drain
    bind_set(2'd1, 3'd2);
    rec(12'h701); rec(12'h702); rec(12'h703);
    marshal(1'b1, 3'd1);
    bind_we = 1'b1; bind_seg = 2'd1; bind_core = 3'd5;
    cycle(1'b0);
    drain_all();
    add_exp(12'h701, 2); add_exp(12'h702, 2); add_exp(12'h703, 2);
    expect_log("R7");
    rec(12'h704);
    marshal(1'b1, 3'd1);
    drain_all();
    add_exp(12'h704, 5);
    expect_log("R7");

    // R9: tagged stores during a drain
    rec(12'h501); rec(12'h502);
    marshal(1'b0, 3'd3);
    gen_valid = 1'b1; gen_addr = 12'h5C0; cycle(1'b0);
    gen_valid = 1'b1; gen_addr = 12'h5D0; cycle(1'b0);
    drain_all();
    add_exp(12'h501, 3); add_exp(12'h502, 3);
    expect_log("R9");
    marshal(1'b0, 3'd4);
    drain_all();
    add_exp(12'h5C0, 4);
    expect_log("R9");

    // R9: tagged store on the final accepting edge
    rec(12'h5E0);
    marshal(1'b0, 3'd2);
    gen_valid = 1'b1; gen_addr = 12'h5F0; cycle(1'b1);
    drain_all();
    add_exp(12'h5E0, 2);
    expect_log("R9");
    marshal(1'b0, 3'd2);
    drain_all();
    add_exp(12'h5F0, 2);
    expect_log("R9");

    // R10: marshal during drain ignored
    rec(12'h601); rec(12'h602);
    marshal(1'b0, 3'd1);
    mar_valid = 1'b1; mar_is_seg = 1'b0; mar_arg = 3'd4;
    cycle(1'b0);
    drain_all();
    add_exp(12'h601, 1); add_exp(12'h602, 1);
    expect_log("R10");
    marshal(1'b0, 3'd4);
    drain_all();
    expect_log("R8");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule